// File: doc/BRIEF.md
# Slot-Aligned Optical Crosspoint Gate Sequencer

This block sets the four on/off amplifier gates of a two-input, two-output split-and-gate optical switch once per time slot. Each input waveguide splits into two gates, and each gate feeds one output. A gate pattern therefore selects, for every output, which input (if any) reaches it. An upstream control-channel receiver delivers a short routing word with a valid strobe. The word arrives during the slot before the packet it steers. The block keeps the newest word of the current slot. At the next slot boundary it turns that word into a gate pattern and holds the pattern unchanged for the whole slot, so gates only move inside the dark guard time at the start of a slot.

A free-running cycle counter divides the control clock into fixed-length slots. The default is 32 cycles, which is 0.512 µs at 62.5 MHz. The counter value and a one-cycle slot-start pulse are exposed so that transmit-side logic can line up with the same boundaries. If a slot passes with no routing word, the following slot is blocked.

Top module: `optical_gate_ctrl`

## Requirements
- R1: While `rst` is high (synchronous, active high), `gate_en` is 0000, `slot_cycle` is 0 and `slot_start` is 0. The cycle in which reset is first low is cycle 0 of slot 0.
- R2: `slot_cycle` counts 0,1,…,31 and then wraps to 0. `slot_start` is high exactly in the cycles where `slot_cycle` is 0.
- R3: Mode code 3'd1 (straight routing, input 1 to output 1 and input 2 to output 2) gives `gate_en` = 4'b1001. Bit 0 is gate A (input 1 to output 1), bit 1 is gate B (input 1 to output 2), bit 2 is gate C (input 2 to output 1) and bit 3 is gate D (input 2 to output 2).
- R4: Mode code 3'd2 (swapped routing, input 1 to output 2 and input 2 to output 1) gives `gate_en` = 4'b0110.
- R5: Mode code 3'd3 (input 1 copied to both outputs) gives 4'b0011. Mode code 3'd4 (input 2 copied to both outputs) gives 4'b1100.
- R6: Mode code 3'd0 and the unused codes 3'd5, 3'd6 and 3'd7 give 4'b0000.
- R7: A word accepted in any cycle of slot N, including its last cycle, sets `gate_en` from cycle 0 of slot N+1. `gate_en` then stays constant through that slot.
- R8: When several words are accepted in one slot, only the last one decides the next slot's pattern.
- R9: A slot with no accepted word is followed by a slot with `gate_en` = 0000. A word steers exactly one slot. Slot 0 after reset is always 0000.
- R10: Asserting reset in the middle of a slot discards any word accepted earlier in that slot.
- R11: Two gates that feed the same output (A with C, or B with D) are never enabled together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Routing word strobe, one word per high cycle |
| cmd_mode | input | 3 | Routing mode code |
| gate_en | output | 4 | Gate enables, bit 0 = A through bit 3 = D |
| slot_start | output | 1 | High in the first cycle of every slot |
| slot_cycle | output | 5 | Cycle index within the current slot |

## Verification
All eight mode codes are each sent once, at different offsets within their slots, including the first and the last cycle. Every pattern is compared with a table of gates derived from the input-to-output paths each mode needs. This separates a wrong gate mapping from a wrong boundary. It also shows whether a word arriving in the last cycle still reaches the next slot. Slots with two words tell "last wins" apart from "first wins". Empty slots tell a pattern that clears after one slot apart from one that is held. A reset halfway through a slot, after a word was accepted, shows whether that pending word survives into the restarted slot sequence.

// File: rtl/gate_ctl_pkg.sv
package gate_ctl_pkg;

    typedef enum logic [2:0] {
        MODE_OFF    = 3'd0,
        MODE_STRAIT = 3'd1,
        MODE_SWAP   = 3'd2,
        MODE_COPY1  = 3'd3,
        MODE_COPY2  = 3'd4
    } route_mode_e;

    // Per-output feed selection: enabled and which input drives it.
    typedef struct packed {
        logic en;
        logic src;   // 0 = input 1, 1 = input 2
    } out_feed_t;

    typedef struct packed {
        out_feed_t o2;
        out_feed_t o1;
    } route_plan_t;

    localparam int N_IN    = 2;
    localparam int N_OUT   = 2;
    localparam int N_GATES = N_IN * N_OUT;

    function automatic route_mode_e code_to_mode(input logic [2:0] code);
        case (code)
            3'd1:    return MODE_STRAIT;
            3'd2:    return MODE_SWAP;
            3'd3:    return MODE_COPY1;
            3'd4:    return MODE_COPY2;
            default: return MODE_OFF;
        endcase
    endfunction

    function automatic route_plan_t mode_to_plan(input route_mode_e m);
        route_plan_t p;
        p = '0;
        case (m)
            MODE_STRAIT: begin p.o1 = '{1'b1, 1'b0}; p.o2 = '{1'b1, 1'b1}; end
            MODE_SWAP:   begin p.o1 = '{1'b1, 1'b1}; p.o2 = '{1'b1, 1'b0}; end
            MODE_COPY1:  begin p.o1 = '{1'b1, 1'b0}; p.o2 = '{1'b1, 1'b0}; end
            MODE_COPY2:  begin p.o1 = '{1'b1, 1'b1}; p.o2 = '{1'b1, 1'b1}; end
            default:     p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
    parameter int SLOT_CYCLES = 32,
    localparam int CNT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cycle_idx,
    output logic             first_cycle,
    output logic             last_cycle
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign cycle_idx   = cnt_q;
    assign first_cycle = (cnt_q == '0) && !rst;
    assign last_cycle  = (cnt_q == LAST) && !rst;

    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == LAST) |=> (cnt_q == '0));
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/cmd_latch.sv
module cmd_latch
    import gate_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_mode,
    input  logic        slot_end,
    output route_mode_e next_mode
);
    logic        have_q;
    route_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_q <= 1'b0;
            mode_q <= MODE_OFF;
        end else if (slot_end) begin
            have_q <= 1'b0;
            mode_q <= MODE_OFF;
        end else if (cmd_valid) begin
            have_q <= 1'b1;
            mode_q <= code_to_mode(cmd_mode);
        end
    end

    always_comb begin
        if (cmd_valid)   next_mode = code_to_mode(cmd_mode);
        else if (have_q) next_mode = mode_q;
        else             next_mode = MODE_OFF;
    end

    a_r9_clear_at_boundary: assert property (@(posedge clk) disable iff (rst)
        slot_end |=> !have_q);
    a_r8_newest_kept: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !slot_end) |=> (have_q && mode_q == code_to_mode($past(cmd_mode))));

endmodule

// File: rtl/gate_decode.sv
module gate_decode
    import gate_ctl_pkg::*;
(
    input  route_mode_e        mode,
    output logic [N_GATES-1:0] gates
);
    route_plan_t plan;
    out_feed_t   feed [N_OUT];

    assign plan    = mode_to_plan(mode);
    assign feed[0] = plan.o1;
    assign feed[1] = plan.o2;

    // Gate index = input*N_OUT + output: A=0, B=1, C=2, D=3.
    for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
        for (genvar go = 0; go < N_OUT; go++) begin : g_out
            assign gates[gi*N_OUT + go] = feed[go].en && (feed[go].src == 1'(gi));
        end
    end

endmodule

// File: rtl/optical_gate_ctrl.sv
module optical_gate_ctrl
    import gate_ctl_pkg::*;
#(
    parameter int SLOT_CYCLES = 32,
    localparam int CNT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_mode,
    output logic [3:0]       gate_en,
    output logic             slot_start,
    output logic [CNT_W-1:0] slot_cycle
);
    logic               last_cycle;
    route_mode_e        next_mode;
    logic [N_GATES-1:0] next_gates;
    logic [N_GATES-1:0] gate_q;

    slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .cycle_idx   (slot_cycle),
        .first_cycle (slot_start),
        .last_cycle  (last_cycle)
    );

    cmd_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_mode  (cmd_mode),
        .slot_end  (last_cycle),
        .next_mode (next_mode)
    );

    gate_decode u_decode (
        .mode  (next_mode),
        .gates (next_gates)
    );

    always_ff @(posedge clk) begin
        if (rst)             gate_q <= '0;
        else if (last_cycle) gate_q <= next_gates;
    end

    assign gate_en = gate_q;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (gate_en == 4'b0000 && slot_cycle == '0));
    a_r7_hold_in_slot: assert property (@(posedge clk) disable iff (rst)
        (slot_cycle != '0) |-> $stable(gate_en));
    a_r11_one_feed_per_output: assert property (@(posedge clk) disable iff (rst)
        !(gate_en[0] && gate_en[2]) && !(gate_en[1] && gate_en[3]));
    a_r2_pulse_at_zero: assert property (@(posedge clk) disable iff (rst)
        slot_start |-> ($countones(gate_en) <= 2 && slot_cycle == '0));

endmodule

// File: tb/optical_gate_ctrl_test.sv
`timescale 1ns/100ps
module optical_gate_ctrl_test;

    localparam int SLOT = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_mode = 3'd0;
    logic [3:0] gate_en;
    logic       slot_start;
    logic [4:0] slot_cycle;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    logic [3:0] exp_gates;
    int         pend_code;
    int         pend_cnt;
    string      exp_tag;

    always #2.5 clk = ~clk;

    optical_gate_ctrl uut (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_mode   (cmd_mode),
        .gate_en    (gate_en),
        .slot_start (slot_start),
        .slot_cycle (slot_cycle)
    );

    // Gate set from required paths: bit = input*2 + output (A,B,C,D).
    function automatic logic [3:0] paths_to_gates(input int code);
        int src1, src2; // input feeding output1/output2, -1 = none
        logic [3:0] g;
        src1 = -1; src2 = -1;
        if (code == 1) begin src1 = 0; src2 = 1; end
        if (code == 2) begin src1 = 1; src2 = 0; end
        if (code == 3) begin src1 = 0; src2 = 0; end
        if (code == 4) begin src1 = 1; src2 = 1; end
        g = 4'b0000;
        if (src1 >= 0) g[src1*2 + 0] = 1'b1;
        if (src2 >= 0) g[src2*2 + 1] = 1'b1;
        return g;
    endfunction

    function automatic string mode_tag(input int code);
        if (code == 1) return "R3";
        if (code == 2) return "R4";
        if (code == 3 || code == 4) return "R5";
        return "R6";
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_cycle(input int k);
        check(exp_tag, "gate_en", int'(gate_en), int'(exp_gates));
        check("R2", "slot_cycle", int'(slot_cycle), k % SLOT);
        check("R2", "slot_start", int'(slot_start), (k % SLOT) == 0 ? 1 : 0);
        check("R11", "shared output", int'((gate_en[0] & gate_en[2]) | (gate_en[1] & gate_en[3])), 0);
    endtask

    // Model update after the stimulus of cycle k is known.
    task automatic model_step(input int k, input bit v, input int code);
        if (v) begin
            pend_code = code;
            pend_cnt++;
        end
        if ((k % SLOT) == SLOT - 1) begin
            if (pend_cnt == 0) begin
                exp_gates = 4'b0000;
                exp_tag = "R9";
            end else begin
                exp_gates = paths_to_gates(pend_code);
                exp_tag = (pend_cnt > 1) ? {mode_tag(pend_code), "/R8"}
                                         : {mode_tag(pend_code), "/R7"};
            end
            pend_cnt = 0;
        end
    endtask

    task automatic plan1(input int s, input int o, output bit v, output int code);
        v = 1'b0; code = 0;
        if (s <= 7 && o == (s * 9) % SLOT) begin v = 1'b1; code = s; end
        if (s == 9 && o == 3)  begin v = 1'b1; code = 1; end
        if (s == 9 && o == 20) begin v = 1'b1; code = 2; end
        if (s == 10 && o == 31) begin v = 1'b1; code = 3; end
        if (s == 12 && o == 5) begin v = 1'b1; code = 1; end
    endtask

    task automatic plan2(input int s, input int o, output bit v, output int code);
        v = 1'b0; code = 0;
        if (s == 1 && o == 0)  begin v = 1'b1; code = 4; end
        if (s == 2 && o == 15) begin v = 1'b1; code = 5; end
        if (s == 3 && o == 16) begin v = 1'b1; code = 6; end
        if (s == 4 && o == 2)  begin v = 1'b1; code = 7; end
        if (s == 5 && o == 30) begin v = 1'b1; code = 2; end
    endtask

    task automatic drive(input bit v, input int code);
        cmd_valid = v;
        cmd_mode  = v ? 3'(code) : 3'd0;
    endtask

    initial begin
        bit v;
        int code;
        // reset phase
        repeat (3) @(negedge clk);
        check("R1", "gate_en in reset", int'(gate_en), 0);
        check("R1", "slot_cycle in reset", int'(slot_cycle), 0);
        check("R1", "slot_start in reset", int'(slot_start), 0);
        rst = 1'b0;
        #1;
        exp_gates = 4'b0000; pend_cnt = 0; pend_code = 0; exp_tag = "R1";
        for (int k = 0; k < 12 * SLOT + 11; k++) begin
            check_cycle(k);
            plan1(k / SLOT, k % SLOT, v, code);
            drive(v, code);
            model_step(k, v, code);
            @(negedge clk);
            #1;
        end
        // mid-slot reset after a pending word in slot 12
        drive(1'b0, 0);
        rst = 1'b1;
        @(negedge clk);
        #1;
        check("R10", "gate_en in reset", int'(gate_en), 0);
        check("R1", "slot_cycle in reset", int'(slot_cycle), 0);
        check("R1", "slot_start in reset", int'(slot_start), 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        exp_gates = 4'b0000; pend_cnt = 0; pend_code = 0; exp_tag = "R10";
        for (int k = 0; k < 7 * SLOT; k++) begin
            check_cycle(k);
            plan2(k / SLOT, k % SLOT, v, code);
            drive(v, code);
            model_step(k, v, code);
            @(negedge clk);
            #1;
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule